// File: doc/BRIEF.md
# Crosspoint Configuration Port

This block is the programming front end of a crosspoint switch. An external controller drives two 7-bit address fields, a 4-bit instruction code and a cycle-enable strobe, all timed by a dedicated configuration clock. On each falling edge of that clock the port captures the strobe together with the fields. On the rising edge that follows, it carries out the captured instruction.

Write instructions do four things: they connect an output to an input, disconnect an output, clear every connection at once, or set the buffer options of an input or output port. Read instructions return one output buffer's settings, or whether a given input drives a given output, on a 5-bit readback bus. The block holds the whole configuration: one source index and a valid bit for each output, four buffer bits for each output port and four for each input port. It presents all of it in parallel to the switch fabric.

Top module: `xpt_cfg_port`

## Requirements
- R1: The cycle-enable strobe, both address fields and the instruction are captured on the falling edge of `cfg_clk_i`. The captured instruction takes effect on the next rising edge, and input changes after that falling edge do not alter it.
- R2: Instruction 0x4 (connect) makes output A take input B as its source (`conn_vld_o[A]`=1, `conn_sel_o[A*7+:7]`=B). This happens only when A < N_OUT and B < N_IN.
- R3: A connect to an output that already has a source replaces that source, so each output has exactly one source.
- R4: Instruction 0x5 (disconnect) clears output A's connection only when its current source equals B. Otherwise it has no effect.
- R5: Instruction 0x1 (reset crosspoint) clears every connection in one cycle. Buffer settings and readback stay unchanged.
- R6: Instruction 0x3 (output buffer) stores B[3:0] for output A with this layout: bit 3 mode, bit 2 neighbour clock select, bit 1 output enable, bit 0 invert. The result appears on `obuf_cfg_o[A*4+:4]`.
- R7: Outputs 2k and 2k+1 form a pair. Writing an output buffer with bit 2 set clears bit 2 of its pair partner in the same cycle, so at most one output of a pair selects the neighbour clock.
- R8: Instruction 0x2 (I/O buffer) stores B[3:0] for input port A (A < N_IN) on `iob_cfg_o[A*4+:4]`.
- R9: Instruction 0x8 (read output buffer) loads `rdbk_o` with {0, output A's four buffer bits}. If A is out of range it loads zero.
- R10: Instruction 0x9 (read crosspoint) loads `rdbk_o` bit 0 with 1 when output A is connected to input B. Bits 4:1 are zero.
- R11: `rdbk_o` changes only on accepted read instructions. It holds through idle cycles and through all other instructions.
- R12: Cycles with the strobe low have no effect. So do codes 0x0, 0x6, 0x7 and 0xA to 0xF, and writes with an out-of-range address.
- R13: While `rst_ni` is low, all connections, buffer settings and readback are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_en_i | input | 1 | Cycle enable, sensed on falling edge |
| addr_a_i | input | ADDR_W | Address A: output or port select |
| addr_b_i | input | ADDR_W | Address B: input select or buffer bits |
| instr_i | input | 4 | Instruction code |
| rdbk_o | output | 5 | Readback data |
| conn_vld_o | output | N_OUT | Per-output connection valid |
| conn_sel_o | output | N_OUT*ADDR_W | Per-output source input index |
| obuf_cfg_o | output | N_OUT*4 | Per-output buffer settings |
| iob_cfg_o | output | N_IN*4 | Per-input buffer settings |

## Verification
The bench builds the port with N_OUT=8 and N_IN=6 and keeps the 7-bit address width. Both address fields can therefore name ports beyond the populated range, so out-of-range writes and reads are checked for real. Eight outputs give four neighbour pairs, which is enough to exercise the pair clock exclusivity. The small tables also let each whole configuration vector be compared against an expected image after every cycle.

// File: rtl/xpt_cfg_pkg.sv
`timescale 1ns/1ps
package xpt_cfg_pkg;
  localparam int INSTR_W = 4;
  localparam int RB_W    = 5;
  localparam int CFG_W   = 4;

  typedef enum logic [INSTR_W-1:0] {
    OP_NOP     = 4'h0,
    OP_XRST    = 4'h1,
    OP_IOB     = 4'h2,
    OP_OBUF    = 4'h3,
    OP_CONN    = 4'h4,
    OP_DISC    = 4'h5,
    OP_RD_OBUF = 4'h8,
    OP_RD_XPT  = 4'h9
  } op_e;

  typedef struct packed {
    logic mode;
    logic nbr_clk;
    logic oe;
    logic inv;
  } obuf_t;
endpackage

// File: rtl/xpt_cmd_capture.sv
`timescale 1ns/1ps
module xpt_cmd_capture #(
  parameter int ADDR_W = 7
) (
  input  logic                              cfg_clk_i,
  input  logic                              rst_ni,
  input  logic                              cyc_en_i,
  input  logic [ADDR_W-1:0]                 addr_a_i,
  input  logic [ADDR_W-1:0]                 addr_b_i,
  input  logic [xpt_cfg_pkg::INSTR_W-1:0]   instr_i,
  output logic                              cmd_vld_o,
  output logic [xpt_cfg_pkg::INSTR_W-1:0]   cmd_op_o,
  output logic [ADDR_W-1:0]                 cmd_a_o,
  output logic [ADDR_W-1:0]                 cmd_b_o
);
  // falling-edge capture; execution happens on the following rising edge
  always_ff @(negedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_vld_o <= 1'b0;
      cmd_op_o  <= '0;
      cmd_a_o   <= '0;
      cmd_b_o   <= '0;
    end else begin
      cmd_vld_o <= cyc_en_i;
      cmd_op_o  <= instr_i;
      cmd_a_o   <= addr_a_i;
      cmd_b_o   <= addr_b_i;
    end
  end
endmodule

// File: rtl/xpt_conn_table.sv
`timescale 1ns/1ps
module xpt_conn_table
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT  = 128,
  parameter int N_IN   = 128,
  parameter int ADDR_W = 7
) (
  input  logic                     cfg_clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_vld_i,
  input  logic [INSTR_W-1:0]       cmd_op_i,
  input  logic [ADDR_W-1:0]        cmd_a_i,
  input  logic [ADDR_W-1:0]        cmd_b_i,
  output logic [N_OUT-1:0]         conn_vld_o,
  output logic [N_OUT*ADDR_W-1:0]  conn_sel_o,
  output logic                     hit_o
);
  localparam logic [ADDR_W:0] N_IN_L = (ADDR_W+1)'(N_IN);

  logic b_ok;
  logic do_rst, do_conn, do_disc;

  assign b_ok    = {1'b0, cmd_b_i} < N_IN_L;
  assign do_rst  = cmd_vld_i && (cmd_op_i == OP_XRST);
  assign do_conn = cmd_vld_i && (cmd_op_i == OP_CONN) && b_ok;
  assign do_disc = cmd_vld_i && (cmd_op_i == OP_DISC);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic              sel;
    logic              vld_q;
    logic [ADDR_W-1:0] src_q;

    assign sel = (cmd_a_i == ADDR_W'(o));

    always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        src_q <= '0;
      end else if (do_rst) begin
        vld_q <= 1'b0;
      end else if (do_conn && sel) begin
        vld_q <= 1'b1;
        src_q <= cmd_b_i;
      end else if (do_disc && sel && vld_q && (src_q == cmd_b_i)) begin
        vld_q <= 1'b0;
      end
    end

    assign conn_vld_o[o]                 = vld_q;
    assign conn_sel_o[o*ADDR_W +: ADDR_W] = src_q;
  end

  always_comb begin
    hit_o = 1'b0;
    for (int o = 0; o < N_OUT; o++) begin
      if (cmd_a_i == ADDR_W'(o) && conn_vld_o[o] &&
          conn_sel_o[o*ADDR_W +: ADDR_W] == cmd_b_i)
        hit_o = 1'b1;
    end
  end
endmodule

// File: rtl/xpt_buf_table.sv
`timescale 1ns/1ps
module xpt_buf_table
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT  = 128,
  parameter int N_IN   = 128,
  parameter int ADDR_W = 7
) (
  input  logic                    cfg_clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_vld_i,
  input  logic [INSTR_W-1:0]      cmd_op_i,
  input  logic [ADDR_W-1:0]       cmd_a_i,
  input  logic [CFG_W-1:0]        cfg_i,
  output logic [N_OUT*CFG_W-1:0]  obuf_cfg_o,
  output logic [N_IN*CFG_W-1:0]   iob_cfg_o,
  output logic [CFG_W-1:0]        obuf_rd_o
);
  logic  wr_obuf, wr_iob;
  obuf_t new_cfg;

  assign wr_obuf = cmd_vld_i && (cmd_op_i == OP_OBUF);
  assign wr_iob  = cmd_vld_i && (cmd_op_i == OP_IOB);
  assign new_cfg = obuf_t'(cfg_i);

  for (genvar o = 0; o < N_OUT; o++) begin : g_obuf
    obuf_t cfg_q;
    logic  self_hit, mate_hit;

    assign self_hit = wr_obuf && (cmd_a_i == ADDR_W'(o));
    assign mate_hit = wr_obuf && (cmd_a_i == ADDR_W'(o ^ 1)) && new_cfg.nbr_clk;

    always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
      if (!rst_ni)       cfg_q <= '0;
      else if (self_hit) cfg_q <= new_cfg;
      else if (mate_hit) cfg_q.nbr_clk <= 1'b0; // one clock source per pair
    end

    assign obuf_cfg_o[o*CFG_W +: CFG_W] = cfg_q;
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_iob
    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= '0;
      else if (wr_iob && (cmd_a_i == ADDR_W'(i))) cfg_q <= cfg_i;
    end

    assign iob_cfg_o[i*CFG_W +: CFG_W] = cfg_q;
  end

  always_comb begin
    obuf_rd_o = '0;
    for (int o = 0; o < N_OUT; o++) begin
      if (cmd_a_i == ADDR_W'(o)) obuf_rd_o = obuf_cfg_o[o*CFG_W +: CFG_W];
    end
  end
endmodule

// File: rtl/xpt_rdbk_reg.sv
`timescale 1ns/1ps
module xpt_rdbk_reg
  import xpt_cfg_pkg::*;
(
  input  logic                cfg_clk_i,
  input  logic                rst_ni,
  input  logic                cmd_vld_i,
  input  logic [INSTR_W-1:0]  cmd_op_i,
  input  logic [CFG_W-1:0]    obuf_rd_i,
  input  logic                hit_i,
  output logic [RB_W-1:0]     rdbk_o
);
  always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdbk_o <= '0;
    end else if (cmd_vld_i) begin
      if (cmd_op_i == OP_RD_OBUF)     rdbk_o <= {{(RB_W-CFG_W){1'b0}}, obuf_rd_i};
      else if (cmd_op_i == OP_RD_XPT) rdbk_o <= {{(RB_W-1){1'b0}}, hit_i};
    end
  end
endmodule

// File: rtl/xpt_cfg_port.sv
`timescale 1ns/1ps
module xpt_cfg_port
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT  = 128,
  parameter int N_IN   = 128,
  parameter int ADDR_W = 7
) (
  input  logic                     cfg_clk_i,
  input  logic                     rst_ni,
  input  logic                     cyc_en_i,
  input  logic [ADDR_W-1:0]        addr_a_i,
  input  logic [ADDR_W-1:0]        addr_b_i,
  input  logic [INSTR_W-1:0]       instr_i,
  output logic [RB_W-1:0]          rdbk_o,
  output logic [N_OUT-1:0]         conn_vld_o,
  output logic [N_OUT*ADDR_W-1:0]  conn_sel_o,
  output logic [N_OUT*CFG_W-1:0]   obuf_cfg_o,
  output logic [N_IN*CFG_W-1:0]    iob_cfg_o
);
  logic               cmd_vld;
  logic [INSTR_W-1:0] cmd_op;
  logic [ADDR_W-1:0]  cmd_a, cmd_b;
  logic [CFG_W-1:0]   obuf_rd;
  logic               hit;

  xpt_cmd_capture #(.ADDR_W(ADDR_W)) u_cap (
    .cfg_clk_i (cfg_clk_i),
    .rst_ni    (rst_ni),
    .cyc_en_i  (cyc_en_i),
    .addr_a_i  (addr_a_i),
    .addr_b_i  (addr_b_i),
    .instr_i   (instr_i),
    .cmd_vld_o (cmd_vld),
    .cmd_op_o  (cmd_op),
    .cmd_a_o   (cmd_a),
    .cmd_b_o   (cmd_b)
  );

  xpt_conn_table #(.N_OUT(N_OUT), .N_IN(N_IN), .ADDR_W(ADDR_W)) u_conn (
    .cfg_clk_i  (cfg_clk_i),
    .rst_ni     (rst_ni),
    .cmd_vld_i  (cmd_vld),
    .cmd_op_i   (cmd_op),
    .cmd_a_i    (cmd_a),
    .cmd_b_i    (cmd_b),
    .conn_vld_o (conn_vld_o),
    .conn_sel_o (conn_sel_o),
    .hit_o      (hit)
  );

  xpt_buf_table #(.N_OUT(N_OUT), .N_IN(N_IN), .ADDR_W(ADDR_W)) u_buf (
    .cfg_clk_i  (cfg_clk_i),
    .rst_ni     (rst_ni),
    .cmd_vld_i  (cmd_vld),
    .cmd_op_i   (cmd_op),
    .cmd_a_i    (cmd_a),
    .cfg_i      (cmd_b[CFG_W-1:0]),
    .obuf_cfg_o (obuf_cfg_o),
    .iob_cfg_o  (iob_cfg_o),
    .obuf_rd_o  (obuf_rd)
  );

  xpt_rdbk_reg u_rdbk (
    .cfg_clk_i (cfg_clk_i),
    .rst_ni    (rst_ni),
    .cmd_vld_i (cmd_vld),
    .cmd_op_i  (cmd_op),
    .obuf_rd_i (obuf_rd),
    .hit_i     (hit),
    .rdbk_o    (rdbk_o)
  );
endmodule

// File: rtl/xpt_cfg_port_chk.sv
`timescale 1ns/1ps
module xpt_cfg_port_chk
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT  = 128,
  parameter int N_IN   = 128,
  parameter int ADDR_W = 7
) (
  input logic                     cfg_clk_i,
  input logic                     rst_ni,
  input logic                     cmd_vld,
  input logic [INSTR_W-1:0]       cmd_op,
  input logic [RB_W-1:0]          rdbk_o,
  input logic [N_OUT-1:0]         conn_vld_o,
  input logic [N_OUT*ADDR_W-1:0]  conn_sel_o,
  input logic [N_OUT*CFG_W-1:0]   obuf_cfg_o,
  input logic [N_IN*CFG_W-1:0]    iob_cfg_o
);
  logic bad_op;
  assign bad_op = (cmd_op == 4'h0) || (cmd_op == 4'h6) || (cmd_op == 4'h7) || (cmd_op >= 4'hA);

  // R5
  xrst_clears_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    cmd_vld && cmd_op == 4'h1 |=> conn_vld_o == '0 && $stable(obuf_cfg_o) && $stable(iob_cfg_o));

  // R9
  rd_obuf_msb_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    cmd_vld && cmd_op == 4'h8 |=> rdbk_o[RB_W-1] == 1'b0);

  // R10
  rd_xpt_upper_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    cmd_vld && cmd_op == 4'h9 |=> rdbk_o[RB_W-1:1] == '0);

  // R11
  rdbk_hold_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    !cmd_vld |=> $stable(rdbk_o) && $stable(conn_vld_o));

  // R12
  bad_op_ignored_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    cmd_vld && bad_op |=> $stable(conn_vld_o) && $stable(conn_sel_o) &&
                          $stable(obuf_cfg_o) && $stable(iob_cfg_o) && $stable(rdbk_o));

  for (genvar k = 0; k < N_OUT/2; k++) begin : g_pair
    // R7
    nbr_excl_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
      !(obuf_cfg_o[(2*k)*CFG_W+2] && obuf_cfg_o[(2*k+1)*CFG_W+2]));
  end
endmodule

bind xpt_cfg_port xpt_cfg_port_chk #(.N_OUT(N_OUT), .N_IN(N_IN), .ADDR_W(ADDR_W)) u_chk (
  .cfg_clk_i  (cfg_clk_i),
  .rst_ni     (rst_ni),
  .cmd_vld    (cmd_vld),
  .cmd_op     (cmd_op),
  .rdbk_o     (rdbk_o),
  .conn_vld_o (conn_vld_o),
  .conn_sel_o (conn_sel_o),
  .obuf_cfg_o (obuf_cfg_o),
  .iob_cfg_o  (iob_cfg_o)
);

// File: tb/xpt_cfg_port_test.sv
`timescale 1ns/1ps
module xpt_cfg_port_test;
  localparam int N_OUT = 8;
  localparam int N_IN  = 6;
  localparam int AW    = 7;

  logic                cfg_clk_i = 1'b0;
  logic                rst_ni    = 1'b0;
  logic                cyc_en_i  = 1'b0;
  logic [AW-1:0]       addr_a_i  = '0;
  logic [AW-1:0]       addr_b_i  = '0;
  logic [3:0]          instr_i   = '0;
  logic [4:0]          rdbk_o;
  logic [N_OUT-1:0]    conn_vld_o;
  logic [N_OUT*AW-1:0] conn_sel_o;
  logic [N_OUT*4-1:0]  obuf_cfg_o;
  logic [N_IN*4-1:0]   iob_cfg_o;

  int checks = 0;
  int fails  = 0;

  always #5 cfg_clk_i = ~cfg_clk_i;

  xpt_cfg_port #(.N_OUT(N_OUT), .N_IN(N_IN), .ADDR_W(AW)) uut (
    .cfg_clk_i  (cfg_clk_i),
    .rst_ni     (rst_ni),
    .cyc_en_i   (cyc_en_i),
    .addr_a_i   (addr_a_i),
    .addr_b_i   (addr_b_i),
    .instr_i    (instr_i),
    .rdbk_o     (rdbk_o),
    .conn_vld_o (conn_vld_o),
    .conn_sel_o (conn_sel_o),
    .obuf_cfg_o (obuf_cfg_o),
    .iob_cfg_o  (iob_cfg_o)
  );

  typedef struct packed {
    logic       en;
    logic [3:0] op;
    logic [6:0] a;
    logic [6:0] b;
    logic [4:0] rb;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'h4, 7'd0, 7'd1,  5'h00, 4'd2},  // R2 connect 0<-1
    '{1'b1, 4'h9, 7'd0, 7'd1,  5'h01, 4'd10}, // R10 hit
    '{1'b1, 4'h9, 7'd0, 7'd2,  5'h00, 4'd10}, // R10 miss
    '{1'b1, 4'h4, 7'd0, 7'd2,  5'h00, 4'd3},  // R3 replace
    '{1'b1, 4'h9, 7'd0, 7'd1,  5'h00, 4'd3},
    '{1'b1, 4'h9, 7'd0, 7'd2,  5'h01, 4'd3},
    '{1'b1, 4'h3, 7'd2, 7'd11, 5'h01, 4'd11}, // R11 write keeps rdbk
    '{1'b1, 4'h8, 7'd2, 7'd0,  5'h0B, 4'd9},  // R9
    '{1'b1, 4'h0, 7'd2, 7'd0,  5'h0B, 4'd12}, // R12 nop
    '{1'b0, 4'h9, 7'd0, 7'd2,  5'h0B, 4'd12}, // R12 strobe low
    '{1'b1, 4'h7, 7'd0, 7'd0,  5'h0B, 4'd12},
    '{1'b1, 4'h5, 7'd0, 7'd1,  5'h0B, 4'd4},  // R4 non-matching
    '{1'b1, 4'h9, 7'd0, 7'd2,  5'h01, 4'd4},
    '{1'b1, 4'h5, 7'd0, 7'd2,  5'h01, 4'd4},  // R4 matching
    '{1'b1, 4'h9, 7'd0, 7'd2,  5'h00, 4'd4},
    '{1'b1, 4'h4, 7'd8, 7'd0,  5'h00, 4'd12}, // R12 A out of range
    '{1'b1, 4'h4, 7'd1, 7'd6,  5'h00, 4'd12}, // R12 B out of range
    '{1'b1, 4'h9, 7'd1, 7'd6,  5'h00, 4'd12},
    '{1'b1, 4'h3, 7'd4, 7'd6,  5'h00, 4'd6},  // R6
    '{1'b1, 4'h3, 7'd5, 7'd4,  5'h00, 4'd7},  // R7 partner clears
    '{1'b1, 4'h8, 7'd4, 7'd0,  5'h02, 4'd7},
    '{1'b1, 4'h8, 7'd5, 7'd0,  5'h04, 4'd6},
    '{1'b1, 4'h8, 7'd9, 7'd0,  5'h00, 4'd9},
    '{1'b1, 4'h2, 7'd3, 7'd9,  5'h00, 4'd8},  // R8
    '{1'b1, 4'h8, 7'd2, 7'd0,  5'h0B, 4'd9}
  };

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called just after a rising edge; returns just after the executing rising edge
  task automatic cyc(input logic en, input logic [3:0] op, input logic [6:0] a, input logic [6:0] b);
    cyc_en_i = en; instr_i = op; addr_a_i = a; addr_b_i = b;
    @(negedge cfg_clk_i);
    @(posedge cfg_clk_i);
    #1;
    cyc_en_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge cfg_clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] obuf_img;
    #12;
    // R13 reset state
    chk(64'(rdbk_o), 0, "R13 rdbk");
    chk(64'(conn_vld_o), 0, "R13 conn_vld");
    chk(64'(obuf_cfg_o), 0, "R13 obuf");
    chk(64'(iob_cfg_o), 0, "R13 iob");
    rst_ni = 1'b1;
    @(posedge cfg_clk_i); #1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].en, VEC[i].op, VEC[i].a, VEC[i].b);
      chk(64'(rdbk_o), 64'(VEC[i].rb), $sformatf("R%0d vec%0d rdbk", VEC[i].req, i));
    end

    // R8 / R6 / R7 images
    chk(64'(iob_cfg_o[3*4 +: 4]), 64'h9, "R8 iob port3");
    obuf_img = 32'h0;
    obuf_img[2*4 +: 4] = 4'hB;
    obuf_img[4*4 +: 4] = 4'h2;
    obuf_img[5*4 +: 4] = 4'h4;
    chk(64'(obuf_cfg_o), 64'(obuf_img), "R7 obuf image");
    chk(64'(conn_vld_o), 0, "R12 out-of-range connect ignored");

    // R1: fields change after the falling edge; captured values win
    cyc_en_i = 1'b1; instr_i = 4'h4; addr_a_i = 7'd3; addr_b_i = 7'd2;
    @(negedge cfg_clk_i); #1;
    instr_i = 4'h5; addr_b_i = 7'd5; cyc_en_i = 1'b0;
    @(posedge cfg_clk_i); #1;
    chk(64'(conn_vld_o[3]), 1, "R1 captured connect");
    chk(64'(conn_sel_o[3*AW +: AW]), 2, "R1 captured B");

    // R12 undefined codes
    cyc(1'b1, 4'h4, 7'd0, 7'd1);
    for (int op = 10; op < 16; op++) begin
      cyc(1'b1, 4'(op), 7'd0, 7'd2);
      chk(64'(conn_sel_o[0 +: AW]), 1, "R12 undefined op conn_sel");
      chk(64'(conn_vld_o), 64'h09, "R12 undefined op conn_vld");
    end
    cyc(1'b1, 4'h6, 7'd0, 7'd2);
    chk(64'(obuf_cfg_o), 64'(obuf_img), "R12 op6 obuf");

    // R5 reset crosspoint
    cyc(1'b1, 4'h4, 7'd5, 7'd4);
    chk(64'(conn_vld_o), 64'h29, "R2 three outputs connected");
    cyc(1'b1, 4'h1, 7'd0, 7'd0);
    chk(64'(conn_vld_o), 0, "R5 all cleared");
    chk(64'(obuf_cfg_o), 64'(obuf_img), "R5 obuf kept");
    chk(64'(iob_cfg_o[3*4 +: 4]), 64'h9, "R5 iob kept");
    chk(64'(rdbk_o), 64'h0B, "R5 rdbk kept");
    cyc(1'b1, 4'h9, 7'd3, 7'd2);
    chk(64'(rdbk_o), 0, "R10 after reset crosspoint");

    // R13 asynchronous reset mid-run
    #2; rst_ni = 1'b0; #1;
    chk(64'(obuf_cfg_o), 0, "R13 obuf cleared");
    chk(64'(iob_cfg_o), 0, "R13 iob cleared");
    rst_ni = 1'b1;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule